// File: doc/BRIEF.md
# Double-Word Memory Cycle Sequencer

The block runs every memory access of a 16-bit processor through a fixed six-step schedule. The requester starts an access by pulsing the address-load strobe together with an address. An internal step counter then goes from 1 to 6 and returns to idle. Read data is captured from a small internal word array into two buffers at fixed steps. The first buffer holds the word at the latched address. The second holds its partner word, whose address differs only in bit 0. Writes are accepted only at fixed steps. A write at step 3 switches the access into paired-word mode, so a write at step 4 goes to the partner address.

Strobes that arrive at the wrong time get one of three responses. An access-start request during an active access, or a read at step 3 or 4, raises the wait output, and the requester holds its strobe until the wait drops. A read at step 1 or 2, or a write at step 1, 2 or 5, is a protocol violation. It produces a one-cycle error pulse and changes nothing. The array covers the lowest 2^MEM_AW word addresses. Addresses above that range read as zero and drop writes.

Top module: `dwmem_seq`

## Requirements
- R1: After reset, busy_o, wait_o, rd_err_o and wr_err_o are low, rd_data_o is 0 and every array word is 0.
- R2: addr_ld_i while idle latches addr_i. busy_o is then high for exactly six cycles (steps 1 to 6), after which the block is idle.
- R3: addr_ld_i while busy_o is high raises wait_o in the same cycle. It starts no access and does not change the latched address or the step sequence.
- R4: rd_data_o at step 5 equals the array word at the latched address as it was just before the step-3 clock edge. A write in that same cycle is not seen.
- R5: rd_data_o at step 6 equals the array word at the latched address with bit 0 inverted, as it was just before the step-4 clock edge.
- R6: rd_i at step 3 or 4 raises wait_o combinationally in that cycle.
- R7: rd_i at step 1 or 2 makes rd_err_o high for exactly the next cycle. rd_err_o is low in every other cycle.
- R8: When idle and through steps 1 to 5, rd_data_o shows the step-3 word captured by the most recent access (0 if there was none).
- R9: wr_i at step 3 stores wr_data_i at the latched address and sets paired mode. wr_i at step 4 in paired mode stores at the latched address with bit 0 inverted.
- R10: wr_i at step 4 without a step-3 write in the same access stores at the latched address. Paired mode is clear at the start of every access.
- R11: wr_i at step 1, 2 or 5 makes wr_err_o high for exactly the next cycle and leaves the array unchanged. wr_i at step 6 or while idle is ignored.
- R12: A latched address with any bit at or above MEM_AW set reads as 0, and writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_ld_i | input | 1 | Start-access strobe |
| addr_i | input | 16 | Word address for the access |
| rd_i | input | 1 | Data read strobe |
| rd_data_o | output | 16 | Read data |
| wr_i | input | 1 | Data write strobe |
| wr_data_i | input | 16 | Write data |
| busy_o | output | 1 | Access in progress (steps 1 to 6) |
| wait_o | output | 1 | Requester must hold its strobe |
| rd_err_o | output | 1 | Early-read violation pulse |
| wr_err_o | output | 1 | Early-write violation pulse |

## Verification
An off-by-one in the step counter shows at the ports at once. busy_o gets the wrong length, and wait_o or an error pulse appears on a strobe one step away from where it belongs. A wrong paired-mode flag or a wrong partner address cannot be seen when the write happens. It appears only when a later access reads that word back at step 5 or 6. For that reason the random stimulus reads often, and the run ends with a sweep that reads every array word. A capture that takes the post-write value is visible at step 5 or 6 of the very access that wrote it.

// File: rtl/dwmem_pkg.sv
package dwmem_pkg;
  typedef logic [2:0] step_t;
  localparam step_t STEP_IDLE = 3'd0;
  localparam step_t STEP_FIRST = 3'd1;
  localparam step_t STEP_EARLY = 3'd2;
  localparam step_t STEP_CAP_A = 3'd3;
  localparam step_t STEP_CAP_B = 3'd4;
  localparam step_t STEP_RD_A = 3'd5;
  localparam step_t STEP_LAST = 3'd6;
endpackage

// File: rtl/dwmem_step_ctr.sv
module dwmem_step_ctr
  import dwmem_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mark_pair_i,
  output step_t             step_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pair_o
);
  step_t step_q;
  logic [ADDR_W-1:0] addr_q;
  logic pair_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= STEP_IDLE;
      addr_q <= '0;
      pair_q <= 1'b0;
    end else if (step_q == STEP_IDLE) begin
      if (start_i) begin
        step_q <= STEP_FIRST;
        addr_q <= addr_i;
        pair_q <= 1'b0;
      end
    end else if (step_q == STEP_LAST) begin
      step_q <= STEP_IDLE;
      pair_q <= 1'b0;
    end else begin
      step_q <= step_q + 3'd1;
      if (mark_pair_i) pair_q <= 1'b1;
    end
  end

  assign step_o = step_q;
  assign addr_o = addr_q;
  assign pair_o = pair_q;
endmodule

// File: rtl/dwmem_array.sv
module dwmem_array #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int MEM_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic w_hit, a_hit, b_hit;

  assign w_hit = (waddr_i[ADDR_W-1:MEM_AW] == '0);
  assign a_hit = (raddr_a_i[ADDR_W-1:MEM_AW] == '0);
  assign b_hit = (raddr_b_i[ADDR_W-1:MEM_AW] == '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && w_hit && (waddr_i[MEM_AW-1:0] == MEM_AW'(g))) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = a_hit ? mem_q[raddr_a_i[MEM_AW-1:0]] : '0;
  assign rdata_b_o = b_hit ? mem_q[raddr_b_i[MEM_AW-1:0]] : '0;
endmodule

// File: rtl/dwmem_rdbuf.sv
module dwmem_rdbuf #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_a_i,
  input  logic [DATA_W-1:0] data_a_i,
  input  logic              cap_b_i,
  input  logic [DATA_W-1:0] data_b_i,
  input  logic              sel_b_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] buf_a_q, buf_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_a_q <= '0;
      buf_b_q <= '0;
    end else begin
      if (cap_a_i) buf_a_q <= data_a_i;
      if (cap_b_i) buf_b_q <= data_b_i;
    end
  end

  assign rd_data_o = sel_b_i ? buf_b_q : buf_a_q;
endmodule

// File: rtl/dwmem_seq.sv
module dwmem_seq
  import dwmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int MEM_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              busy_o,
  output logic              wait_o,
  output logic              rd_err_o,
  output logic              wr_err_o
);
  step_t step_q;
  logic [ADDR_W-1:0] addr_q, partner_addr, waddr;
  logic pair_q, start, wr_first, wr_second, we;
  logic [DATA_W-1:0] rdata_a, rdata_b;
  logic rd_err_q, wr_err_q;

  assign start     = addr_ld_i && (step_q == STEP_IDLE);
  assign wr_first  = wr_i && (step_q == STEP_CAP_A);
  assign wr_second = wr_i && (step_q == STEP_CAP_B);
  assign we        = wr_first || wr_second;
  assign partner_addr = addr_q ^ ADDR_W'(1);
  assign waddr     = (wr_second && pair_q) ? partner_addr : addr_q;

  dwmem_step_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .addr_i(addr_i),
    .mark_pair_i(wr_first), .step_o(step_q), .addr_o(addr_q), .pair_o(pair_q)
  );

  dwmem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .waddr_i(waddr), .wdata_i(wr_data_i),
    .raddr_a_i(addr_q), .rdata_a_o(rdata_a),
    .raddr_b_i(partner_addr), .rdata_b_o(rdata_b)
  );

  dwmem_rdbuf #(.DATA_W(DATA_W)) u_rdbuf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cap_a_i(step_q == STEP_CAP_A), .data_a_i(rdata_a),
    .cap_b_i(step_q == STEP_CAP_B), .data_b_i(rdata_b),
    .sel_b_i(step_q == STEP_LAST), .rd_data_o(rd_data_o)
  );

  // violation pulses, one cycle after the offending strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_err_q <= 1'b0;
      wr_err_q <= 1'b0;
    end else begin
      rd_err_q <= rd_i && (step_q == STEP_FIRST || step_q == STEP_EARLY);
      wr_err_q <= wr_i && (step_q == STEP_FIRST || step_q == STEP_EARLY ||
                           step_q == STEP_RD_A);
    end
  end

  assign busy_o   = (step_q != STEP_IDLE);
  assign wait_o   = (addr_ld_i && busy_o) ||
                    (rd_i && (step_q == STEP_CAP_A || step_q == STEP_CAP_B));
  assign rd_err_o = rd_err_q;
  assign wr_err_o = wr_err_q;
endmodule

// File: rtl/dwmem_seq_chk.sv
module dwmem_seq_chk
  import dwmem_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_ld_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              busy_o,
  input logic              wait_o,
  input logic              rd_err_o,
  input logic              wr_err_o,
  input step_t             step_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic              pair_q
);
  p_step_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= STEP_LAST);
  p_busy_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(addr_ld_i));
  p_step_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && step_q != STEP_LAST) |=> (step_q == $past(step_q) + 3'd1));
  p_busy_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == STEP_LAST) |=> !busy_o);
  p_ld_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_ld_i && busy_o) |-> wait_o);
  p_addr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && step_q != STEP_LAST) |=> $stable(addr_q));
  p_rd_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (step_q == STEP_CAP_A || step_q == STEP_CAP_B)) |-> wait_o);
  p_rd_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (step_q == STEP_FIRST || step_q == STEP_EARLY)) |=> rd_err_o);
  p_rd_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && (step_q == STEP_FIRST || step_q == STEP_EARLY)) |=> !rd_err_o);
  p_wr_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (step_q == STEP_FIRST || step_q == STEP_EARLY || step_q == STEP_RD_A))
      |=> wr_err_o);
  p_pair_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !pair_q);
  p_pair_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !pair_q);
endmodule

bind dwmem_seq dwmem_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_ld_i(addr_ld_i), .rd_i(rd_i), .wr_i(wr_i),
  .busy_o(busy_o), .wait_o(wait_o), .rd_err_o(rd_err_o), .wr_err_o(wr_err_o),
  .step_q(step_q), .addr_q(addr_q), .pair_q(pair_q)
);

// File: tb/dwmem_seq_tb_top.sv
module dwmem_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW = 6;
  localparam int DEPTH = 1 << MEM_AW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic addr_ld_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic rd_i = 1'b0;
  logic wr_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic busy_o, wait_o, rd_err_o, wr_err_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [15:0] mm [DEPTH];
  int m_step = 0;
  logic [15:0] m_addr = '0;
  bit m_pair = 1'b0;
  logic [15:0] m_buf_a = '0, m_buf_b = '0;
  bit m_rerr = 1'b0, m_werr = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dwmem_seq #(.ADDR_W(16), .DATA_W(16), .MEM_AW(MEM_AW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_ld_i(addr_ld_i), .addr_i(addr_i),
    .rd_i(rd_i), .rd_data_o(rd_data_o), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .busy_o(busy_o), .wait_o(wait_o), .rd_err_o(rd_err_o), .wr_err_o(wr_err_o)
  );

  function automatic logic [15:0] m_read(logic [15:0] a);
    return (a[15:MEM_AW] == '0) ? mm[a[MEM_AW-1:0]] : 16'h0;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s step=%0d actual=%h expected=%h", tag, m_step, act, exp);
    end
  endtask

  // one clock: drive at negedge, check outputs, update model at posedge
  task automatic step(bit ld, logic [15:0] a, bit rd, bit wr, logic [15:0] wd);
    logic [15:0] wa;
    @(negedge clk_i);
    addr_ld_i = ld; addr_i = a; rd_i = rd; wr_i = wr; wr_data_i = wd;
    #1;
    chk("R2 busy", 16'(busy_o), 16'(m_step != 0));
    chk("R3/R6 wait", 16'(wait_o),
        16'((ld && m_step != 0) || (rd && (m_step == 3 || m_step == 4))));
    chk("R7 rd_err", 16'(rd_err_o), 16'(m_rerr));
    chk("R11 wr_err", 16'(wr_err_o), 16'(m_werr));
    if (m_step == 5) chk("R4 rd_data", rd_data_o, m_buf_a);
    else if (m_step == 6) chk("R5 rd_data", rd_data_o, m_buf_b);
    else chk("R8 rd_data", rd_data_o, m_buf_a);
    @(posedge clk_i);
    m_rerr = rd && (m_step == 1 || m_step == 2);
    m_werr = wr && (m_step == 1 || m_step == 2 || m_step == 5);
    if (m_step == 3) m_buf_a = m_read(m_addr);
    if (m_step == 4) m_buf_b = m_read(m_addr ^ 16'h1);
    if (wr && (m_step == 3 || m_step == 4)) begin
      wa = (m_step == 4 && m_pair) ? (m_addr ^ 16'h1) : m_addr;
      if (wa[15:MEM_AW] == '0) mm[wa[MEM_AW-1:0]] = wd;
      if (m_step == 3) m_pair = 1'b1;
    end
    if (m_step == 0) begin
      if (ld) begin m_step = 1; m_addr = a; m_pair = 1'b0; end
    end else if (m_step == 6) begin
      m_step = 0; m_pair = 1'b0;
    end else m_step++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 16'h0, 0, 0, 16'h0);
  endtask

  // full access: rd_mask/wr_mask bit k = strobe at step k
  task automatic access(logic [15:0] a, logic [6:0] rd_m, logic [6:0] wr_m,
                        logic [15:0] d3, logic [15:0] d4);
    step(1, a, 0, 0, 16'h0);
    for (int k = 1; k <= 6; k++)
      step(0, 16'h0, rd_m[k], wr_m[k], (k == 4) ? d4 : d3);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    void'($urandom(32'h5eed_0d1e));
    #3;
    // R1: reset state
    chk("R1 busy", 16'(busy_o), 16'h0);
    chk("R1 wait", 16'(wait_o), 16'h0);
    chk("R1 errs", {14'h0, rd_err_o, wr_err_o}, 16'h0);
    chk("R1 rd_data", rd_data_o, 16'h0);
    #(2*CLK_PERIOD);
    rst_ni = 1'b1;
    idle(2);

    // R9: paired write at steps 3 and 4, then read both back
    access(16'h0010, 7'b0, 7'b0011000, 16'hA5A5, 16'h5A5A);
    access(16'h0010, 7'b1100000, 7'b0, 16'h0, 16'h0);
    access(16'h0011, 7'b1100000, 7'b0, 16'h0, 16'h0);
    // R10: step-4 write alone goes to the latched address
    access(16'h0021, 7'b0, 7'b0010000, 16'h0, 16'hBEEF);
    access(16'h0021, 7'b1100000, 7'b0, 16'h0, 16'h0);
    // R7/R11: early strobes, writes at 6 and idle ignored
    access(16'h0021, 7'b0000110, 7'b1100110, 16'hDEAD, 16'h0);
    step(0, 16'h0021, 1, 1, 16'hF00D);
    access(16'h0020, 7'b1100000, 7'b0, 16'h0, 16'h0);
    // R4: capture precedes a same-cycle write
    access(16'h0030, 7'b0100000, 7'b0001000, 16'h1234, 16'h0);
    access(16'h0030, 7'b0100000, 7'b0, 16'h0, 16'h0);
    // R3: load while busy stalls, sequence unchanged
    step(1, 16'h0030, 0, 0, 16'h0);
    for (int k = 1; k <= 6; k++) step(1, 16'h0005, (k == 5), 0, 16'h0);
    idle(1);
    // R12: out-of-range address
    access(16'h8001, 7'b0, 7'b0011000, 16'h7777, 16'h8888);
    access(16'h8000, 7'b1100000, 7'b0, 16'h0, 16'h0);
    access(16'h0000, 7'b1100000, 7'b0, 16'h0, 16'h0);
    // R8: idle read shows last step-3 word
    idle(3);
    step(0, 16'h0, 1, 0, 16'h0);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      a = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom % DEPTH);
      step(($urandom % 3) == 0, a, ($urandom % 2) == 0, ($urandom % 3) == 0,
           16'($urandom));
    end
    idle(7);
    // sweep: read every word back through steps 5 and 6
    for (int i = 0; i < DEPTH; i += 2)
      access(16'(i), 7'b1100000, 7'b0, 16'h0, 16'h0);
    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule